// File: doc/BRIEF.md
# Watchdog Timer with Alternating Two-Command Clear

This block is a watchdog counter for a small processor core. It counts ticks from one of two sources: a slow free-running oscillator input, or the system clock divided by a power of two. A third setting turns the watchdog off. If software does not clear the counter in time, the counter overflows. When the core is running, an overflow sends a one-cycle reset request to the core. When the core is halted, the overflow sends a one-cycle wake pulse instead.

Software clears the count in one of two ways, chosen by an option input. In single mode, one clear strobe is enough. In dual mode, two different clear strobes must alternate. A strobe that repeats the last accepted command does nothing. This stops a runaway loop that happens to execute one clear command from keeping the watchdog quiet.

Two status flags record why the core last stopped. The timeout flag is set by an overflow. The power-down flag is set on entry to halt. The block also reports whether the core is currently halted.

Top module: `wdt_dual_clear`

## Requirements
- R1: After synchronous reset, the count is zero and to_o, pdf_o, halted_o, sys_rst_o and wake_o are 0. The last accepted dual-mode command is taken to be clr_b_i, so clr_a_i is the first command accepted.
- R2: src_sel_i selects the tick source: 2'b00 and 2'b11 are off, 2'b01 is rising edges of osc_i, and 2'b10 is the divided system clock. While the source is off, the count holds its value and no timeout happens.
- R3: With the divided clock selected, the reset request appears exactly 2^(CNT_W+PRE_W) clock edges after the edge that clears the count. The default is 2^18 edges.
- R4: With dual_mode_i = 0, clr_i clears the count and the prescaler, and clears to_o and pdf_o on the next edge. In this mode clr_a_i and clr_b_i have no effect.
- R5: With dual_mode_i = 1, clr_a_i or clr_b_i clears the count only if the other command was the last one accepted. Repeating the last accepted command has no effect. clr_i has no effect, and clr_a_i and clr_b_i in the same cycle have no effect.
- R6: halt_i clears the count, sets pdf_o and halted_o, and clears to_o on the next edge.
- R7: An overflow while running gives a one-cycle sys_rst_o pulse and sets to_o. The count wraps to zero and keeps counting, so the next pulse comes one full period later.
- R8: An overflow while halted gives a one-cycle wake_o pulse instead of sys_rst_o. It sets to_o, clears halted_o and leaves pdf_o set.
- R9: With the oscillator source selected, the timeout comes after 2^CNT_W rising edges of osc_i. Each edge is counted a fixed number of synchronizer stages after it arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (external or power-up) |
| src_sel_i | input | 2 | Tick source option: off, oscillator, divided clock |
| dual_mode_i | input | 1 | Clear option: 0 single command, 1 alternating pair |
| osc_i | input | 1 | Raw level of the watchdog oscillator |
| clr_i | input | 1 | Single-command clear strobe |
| clr_a_i | input | 1 | First command of the alternating pair |
| clr_b_i | input | 1 | Second command of the alternating pair |
| halt_i | input | 1 | Halt entry strobe |
| to_o | output | 1 | Timeout flag |
| pdf_o | output | 1 | Power-down flag |
| halted_o | output | 1 | Core is in halt |
| sys_rst_o | output | 1 | One-cycle reset request to the core |
| wake_o | output | 1 | One-cycle wake request from halt |

## Verification
The checks look at the exact cycle of each timeout pulse. Because of this, a count that is off by one, a prescaler that is not restarted, or a clear that is wrongly accepted or wrongly ignored shows up at sys_rst_o or wake_o within one period: the pulse comes too early, too late or not at all. If the last-command register holds the wrong value, a timeout appears one period after the last real clear instead of after the ignored strobe. Flag errors show on to_o and pdf_o on the edge right after the strobe that should have changed them.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_OSC  = 2'b01,
    SRC_SYS  = 2'b10,
    SRC_OFF2 = 2'b11
  } wdt_src_e;

  typedef enum logic {
    LAST_A = 1'b0,
    LAST_B = 1'b1
  } wdt_last_e;

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen
  import wdt_pkg::*;
#(
  parameter int PRE_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  wdt_src_e src,
  input  logic     osc_i,
  input  logic     restart_i,
  output logic     tick_o
);

  // Oscillator synchronizer, plus one stage used for edge detection
  logic [SYNC_N:0] osc_sh;
  logic            osc_edge;

  always_ff @(posedge clk) begin
    if (rst) osc_sh <= '0;
    else     osc_sh <= {osc_sh[SYNC_N-1:0], osc_i};
  end

  assign osc_edge = osc_sh[SYNC_N-1] & ~osc_sh[SYNC_N];

  logic sys_tick;

  generate
    if (PRE_W == 0) begin : g_nodiv
      assign sys_tick = 1'b1;
    end else begin : g_div
      localparam logic [PRE_W-1:0] PRE_LAST = '1;
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst || restart_i)  pre_q <= '0;
        else if (src == SRC_SYS) pre_q <= pre_q + 1'b1;
      end
      assign sys_tick = (pre_q == PRE_LAST);
    end
  endgenerate

  always_comb begin
    unique case (src)
      SRC_OSC: tick_o = osc_edge;
      SRC_SYS: tick_o = sys_tick;
      default: tick_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/wdt_clear_seq.sv
module wdt_clear_seq
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dual_i,
  input  logic clr_i,
  input  logic clr_a_i,
  input  logic clr_b_i,
  output logic clr_eff_o
);

  wdt_last_e last_q;
  logic      a_only, b_only, dual_ok;

  assign a_only  = clr_a_i & ~clr_b_i;
  assign b_only  = clr_b_i & ~clr_a_i;
  assign dual_ok = (a_only && last_q == LAST_B) || (b_only && last_q == LAST_A);

  assign clr_eff_o = dual_i ? dual_ok : clr_i;

  always_ff @(posedge clk) begin
    if (rst) last_q <= LAST_B;
    else if (dual_i && dual_ok) last_q <= a_only ? LAST_A : LAST_B;
  end

  // R5: each accepted pair command flips the recorded last command
  a_r5_last_flips: assert property (@(posedge clk) disable iff (rst)
    (dual_i && clr_eff_o) |=> (last_q != $past(last_q)));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic clear_i,
  output logic ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = tick_i && (cnt_q == CNT_MAX) && !clear_i;

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + 1'b1;
  end

  // R4/R6: any clear empties the count
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (cnt_q == '0));

  // R2: no tick and no clear leaves the count untouched
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clear_i) |=> $stable(cnt_q));

  // R7: an overflow wraps the count to zero
  a_r7_wraps: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_dual_clear.sv
module wdt_dual_clear
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] src_sel_i,
  input  logic       dual_mode_i,
  input  logic       osc_i,
  input  logic       clr_i,
  input  logic       clr_a_i,
  input  logic       clr_b_i,
  input  logic       halt_i,
  output logic       to_o,
  output logic       pdf_o,
  output logic       halted_o,
  output logic       sys_rst_o,
  output logic       wake_o
);

  wdt_src_e src;
  logic     clr_eff, restart, tick, ovf;
  logic     to_q, pdf_q, halted_q, sys_rst_q, wake_q;

  assign src     = wdt_src_e'(src_sel_i);
  assign restart = clr_eff | halt_i;

  wdt_clear_seq i_seq (
    .clk       (clk),
    .rst       (rst),
    .dual_i    (dual_mode_i),
    .clr_i     (clr_i),
    .clr_a_i   (clr_a_i),
    .clr_b_i   (clr_b_i),
    .clr_eff_o (clr_eff)
  );

  wdt_tick_gen #(.PRE_W(PRE_W), .SYNC_N(SYNC_N)) i_tick (
    .clk       (clk),
    .rst       (rst),
    .src       (src),
    .osc_i     (osc_i),
    .restart_i (restart),
    .tick_o    (tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .clear_i (restart),
    .ovf_o   (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      to_q      <= 1'b0;
      pdf_q     <= 1'b0;
      halted_q  <= 1'b0;
      sys_rst_q <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      sys_rst_q <= ovf & ~halted_q;
      wake_q    <= ovf &  halted_q;
      if (halt_i) begin
        pdf_q    <= 1'b1;
        to_q     <= 1'b0;
        halted_q <= 1'b1;
      end else if (clr_eff) begin
        pdf_q <= 1'b0;
        to_q  <= 1'b0;
      end else if (ovf) begin
        to_q     <= 1'b1;
        halted_q <= 1'b0;
      end
    end
  end

  assign to_o      = to_q;
  assign pdf_o     = pdf_q;
  assign halted_o  = halted_q;
  assign sys_rst_o = sys_rst_q;
  assign wake_o    = wake_q;

  // R7/R8: reset request and wake never fire together
  a_r7_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(sys_rst_o && wake_o));

  // R7: a reset request always comes with the timeout flag
  a_r7_rst_flags_to: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> to_o);

  // R8: a wake leaves halt with the timeout and power-down flags set
  a_r8_wake_state: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (to_o && pdf_o && !halted_o));

  // R6: halt entry sets power-down and halted, clears timeout
  a_r6_halt_flags: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> (pdf_o && halted_o && !to_o));

  // R4: an accepted single clear drops both flags
  a_r4_single_clear: assert property (@(posedge clk) disable iff (rst)
    (!dual_mode_i && clr_i && !halt_i) |=> (!pdf_o && !to_o));

endmodule

// File: tb/test_wdt_dual_clear.sv
module test_wdt_dual_clear;

  localparam int CLK_NS = 10;
  localparam int CW     = 6;
  localparam int PW     = 2;
  localparam int PERIOD = 1 << (CW + PW);
  localparam int OSC_N  = 1 << CW;

  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic [1:0] src_sel = 2'b10;
  logic       dual = 1'b0;
  logic       osc = 1'b0;
  logic       clr = 1'b0, clr_a = 1'b0, clr_b = 1'b0, halt = 1'b0;
  logic       to_o, pdf_o, halted_o, sys_rst_o, wake_o;

  int n_chk = 0;
  int n_bad = 0;
  int ecount = 0;

  always #(CLK_NS/2) clk = ~clk;

  wdt_dual_clear #(.CNT_W(CW), .PRE_W(PW), .SYNC_N(2)) i_wdt_dual_clear (
    .clk(clk), .rst(rst), .src_sel_i(src_sel), .dual_mode_i(dual),
    .osc_i(osc), .clr_i(clr), .clr_a_i(clr_a), .clr_b_i(clr_b),
    .halt_i(halt), .to_o(to_o), .pdf_o(pdf_o), .halted_o(halted_o),
    .sys_rst_o(sys_rst_o), .wake_o(wake_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    ecount++;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    ecount = 0;
  endtask

  // which: 0 single, 1 cmd A, 2 cmd B, 3 both A and B, 4 halt
  task automatic strobe(input int which, input bit restarts);
    clr   = (which == 0);
    clr_a = (which == 1) || (which == 3);
    clr_b = (which == 2) || (which == 3);
    halt  = (which == 4);
    step();
    clr = 1'b0; clr_a = 1'b0; clr_b = 1'b0; halt = 1'b0;
    if (restarts) ecount = 0;
  endtask

  // Quiet until edge target-1, then the given pulse at edge target
  task automatic expect_pulse(input string req, input int target, input bit is_wake);
    bit seen = 1'b0;
    while (ecount < target - 1) begin
      step();
      if (sys_rst_o || wake_o) seen = 1'b1;
    end
    chk({req, " quiet before timeout"}, int'(seen), 0);
    step();
    chk({req, " reset pulse"}, int'(sys_rst_o), is_wake ? 0 : 1);
    chk({req, " wake pulse"}, int'(wake_o), is_wake ? 1 : 0);
  endtask

  task automatic t_reset_state();
    src_sel = 2'b10; dual = 1'b0;
    do_reset();
    chk("R1 to", int'(to_o), 0);
    chk("R1 pdf", int'(pdf_o), 0);
    chk("R1 halted", int'(halted_o), 0);
    chk("R1 sys_rst", int'(sys_rst_o), 0);
    chk("R1 wake", int'(wake_o), 0);
  endtask

  task automatic t_sys_timeout();
    src_sel = 2'b10; dual = 1'b0;
    do_reset();
    expect_pulse("R3", PERIOD, 1'b0);
    chk("R7 to set", int'(to_o), 1);
    ecount = 0;
    step();
    chk("R7 one-cycle pulse", int'(sys_rst_o), 0);
    expect_pulse("R7 wrap", PERIOD, 1'b0);
  endtask

  task automatic t_single_clear();
    src_sel = 2'b10; dual = 1'b0;
    do_reset();
    expect_pulse("R3", PERIOD, 1'b0);
    repeat (30) step();
    strobe(0, 1'b1);
    chk("R4 to cleared", int'(to_o), 0);
    chk("R4 pdf cleared", int'(pdf_o), 0);
    expect_pulse("R4 restart", PERIOD, 1'b0);
    do_reset();
    repeat (90) step();
    strobe(1, 1'b0);
    repeat (10) step();
    strobe(2, 1'b0);
    expect_pulse("R4 pair ignored", PERIOD, 1'b0);
  endtask

  task automatic t_dual();
    src_sel = 2'b10; dual = 1'b1;
    do_reset();
    repeat (40) step();
    strobe(2, 1'b0);                         // R1/R5: B first is a repeat
    expect_pulse("R5 B-first ignored", PERIOD, 1'b0);
    do_reset();
    repeat (40) step();
    strobe(1, 1'b1);                         // A accepted
    repeat (40) step();
    strobe(1, 1'b0);                         // A repeated: ignored
    repeat (40) step();
    strobe(0, 1'b0);                         // single clear ignored in dual
    expect_pulse("R5 repeat ignored", PERIOD, 1'b0);
    repeat (20) step();
    strobe(2, 1'b1);                         // B accepted
    chk("R5 accepted B clears to", int'(to_o), 0);
    repeat (30) step();
    strobe(2, 1'b0);                         // B repeated: ignored
    expect_pulse("R5 alternate restart", PERIOD, 1'b0);
    strobe(3, 1'b0);                         // both at once: ignored
    chk("R5 both ignored, to kept", int'(to_o), 1);
    strobe(1, 1'b1);
    chk("R5 A after B accepted", int'(to_o), 0);
  endtask

  task automatic t_halt();
    src_sel = 2'b10; dual = 1'b0;
    do_reset();
    repeat (50) step();
    strobe(4, 1'b1);
    chk("R6 pdf set", int'(pdf_o), 1);
    chk("R6 halted set", int'(halted_o), 1);
    chk("R6 to clear", int'(to_o), 0);
    expect_pulse("R8", PERIOD, 1'b1);
    chk("R8 to set", int'(to_o), 1);
    chk("R8 left halt", int'(halted_o), 0);
    chk("R8 pdf kept", int'(pdf_o), 1);
    strobe(0, 1'b1);
    chk("R4 pdf cleared after wake", int'(pdf_o), 0);
    chk("R4 to cleared after wake", int'(to_o), 0);
  endtask

  task automatic t_off();
    bit seen = 1'b0;
    dual = 1'b0;
    src_sel = 2'b00;
    do_reset();
    repeat (2 * PERIOD) begin
      step();
      if (sys_rst_o || wake_o) seen = 1'b1;
    end
    src_sel = 2'b11;
    repeat (PERIOD + 10) begin
      step();
      if (sys_rst_o || wake_o) seen = 1'b1;
    end
    chk("R2 off: no timeout", int'(seen), 0);
    chk("R2 off: to clear", int'(to_o), 0);
    src_sel = 2'b10;
    ecount = 0;
    expect_pulse("R2 count held while off", PERIOD, 1'b0);
  endtask

  task automatic t_osc();
    int pulses = 0;
    src_sel = 2'b01; dual = 1'b0;
    do_reset();
    for (int k = 0; k < OSC_N - 1; k++) begin
      osc = 1'b1; step(); if (sys_rst_o) pulses++;
      step(); if (sys_rst_o) pulses++;
      osc = 1'b0; step(); if (sys_rst_o) pulses++;
      step(); if (sys_rst_o) pulses++;
    end
    repeat (6) begin step(); if (sys_rst_o) pulses++; end
    chk("R9 no timeout before last edge", pulses, 0);
    osc = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step();
      if (sys_rst_o) pulses++;
    end
    osc = 1'b0;
    chk("R9 timeout on last edge", pulses, 1);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL watchdog expired (all requirements): actual hang expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_sys_timeout();
    t_single_clear();
    t_dual();
    t_halt();
    t_off();
    t_osc();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule